// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a serial slave on a two-wire bus. A host uses it to read and write a small bank of 8-bit configuration registers. The block samples the bus clock line and the bus data line with its own system clock. It finds bus start and stop conditions, shifts in the slave address and the direction bit, and acknowledges only its own address. After that it either takes a register pointer and then data bytes, or it sends register contents back to the host. The open-drain data driver appears as an output enable: when `sda_oe_o` is high, the line is pulled low. The current register values are brought out as one flat vector, so the rest of the chip can use them as configuration.

A single strap input has two jobs. Its level replaces bit 1 of the slave address, so two of these slaves can share one bus. When the strap is high, it also switches on a persistence filter on both bus lines. The filter rejects short spikes, which suits noisy boards. When the strap is low, the filter is bypassed and the bus is followed with only the synchroniser delay.

Top module: `twi_cfg_slave`

## Requirements
- R1: After reset, `sda_oe_o` is low, every register reads 0x00 and the register pointer is 0.
- R2: A falling data line while the clock line is high is a START. A START clears the bit counter, releases the data line and begins a new address phase, even in the middle of a byte (repeated START).
- R3: The first byte after a START is taken most significant bit first. It holds a 7-bit address followed by a direction bit, where 1 means read and 0 means write. The slave answers to ADDR_BASE with bit 1 replaced by `strap_i`: 0x28 with the strap low and 0x2A with it high, for the default parameters.
- R4: On an address match, `sda_oe_o` is high through the ninth clock pulse (acknowledge). On a mismatch, the slave does not drive the line and ignores all traffic until the next START.
- R5: In a write, the first byte after the address loads the pointer from its low log2(NUM_REGS) bits. Each later byte is stored at the pointer, and the pointer then advances by one. Every byte is acknowledged.
- R6: The pointer wraps from NUM_REGS-1 to 0.
- R7: In a read, the slave sends the register at the pointer, most significant bit first, and the pointer advances after each byte. A host acknowledge (data low in the ninth pulse) makes the slave send the next register.
- R8: A host not-acknowledge ends the read. The slave releases the line and stays silent until the next START.
- R9: A STOP (data rising while the clock is high) aborts the transfer in progress. A partly received byte is not stored, and the data line is released.
- R10: With `strap_i` high, a pulse on either line shorter than FILT_CYCLES system clocks has no effect on the transfer. For the defaults this is 6 clocks, which is 60 ns at a 10 ns system clock, so pulses under 50 ns are rejected.
- R11: With `strap_i` low, no filtering is done. A 3-clock low pulse on the data line while the clock line is high is seen as a START followed by a STOP, and this aborts the transfer.
- R12: `sda_oe_o` changes only in the cycle after a filtered falling edge of the clock line, a START or a STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND of all drivers) |
| strap_i | input | 1 | Address bit 1 and spike-filter enable |
| sda_oe_o | output | 1 | High pulls the data line low |
| cfg_regs_o | output | NUM_REGS*8 | Register contents; register k in bits [8k+7:8k] |

## Verification
Writes and reads with multiple bytes check the pointer handling. This includes a write that crosses the top register and wraps, and a read that the host ends with a not-acknowledge. Both strap levels are tried with both candidate addresses, so an accepted address and a rejected one can be told apart by the acknowledge bit and by whether the registers change. Byte streams that are cut off, by a STOP or by a repeated START after a few bits, show whether partial bytes leak into the bank. The same byte is then sent with short spikes injected on the data line during clock-high and on the clock line during clock-low. It is sent once with the strap high and once with it low, which separates filtered behaviour from unfiltered behaviour.

// File: rtl/twi_cfg_pkg.sv
package twi_cfg_pkg;

   localparam int BYTE_W = 8;
   localparam int DEV_ADDR_W = 7;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_ADDR  = 3'd1,
      ST_SUBA  = 3'd2,
      ST_WDATA = 3'd3,
      ST_RDATA = 3'd4
   } twi_state_e;

   // Number of system clocks a line change must persist to be accepted.
   function automatic int persist_cycles(input int clk_ps, input int reject_ps);
      return (reject_ps + clk_ps - 1) / clk_ps + 1;
   endfunction

endpackage

// File: rtl/twi_line_filter.sv
module twi_line_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_CYCLES = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   input  logic filt_en_i,
   output logic line_o
);
   localparam int CNT_W = $clog2(FILT_CYCLES + 1);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("twi_line_filter: SYNC_STAGES must be at least 2");
   end
   if (FILT_CYCLES < 1) begin : g_bad_filt
      $error("twi_line_filter: FILT_CYCLES must be at least 1");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   synced;
   logic                   stable_val;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
   end
   assign synced = sync_q[SYNC_STAGES-1];

   if (FILT_CYCLES > 1) begin : g_persist
      logic [CNT_W-1:0] cnt_q;
      logic             held_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q  <= '0;
            held_q <= 1'b1;
         end else if (synced == held_q) begin
            cnt_q <= '0;
         end else if (cnt_q == CNT_W'(FILT_CYCLES - 1)) begin
            held_q <= synced;
            cnt_q  <= '0;
         end else begin
            cnt_q <= cnt_q + CNT_W'(1);
         end
      end
      assign stable_val = held_q;
   end else begin : g_direct
      assign stable_val = synced;
   end

   assign line_o = filt_en_i ? stable_val : synced;

endmodule

// File: rtl/twi_bus_cond.sv
module twi_bus_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_rise_o,
   output logic scl_fall_o,
   output logic start_o,
   output logic stop_o
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_i;
         sda_q <= sda_i;
      end
   end

   assign scl_rise_o = scl_i & ~scl_q;
   assign scl_fall_o = ~scl_i & scl_q;
   assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
   assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;

endmodule

// File: rtl/twi_reg_bank.sv
module twi_reg_bank #(
   parameter int          NUM_REGS = 16,
   parameter int          DATA_W   = 8,
   parameter logic [7:0]  RST_VAL  = 8'h00,
   localparam int         PTR_W    = $clog2(NUM_REGS)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en_i,
   input  logic [PTR_W-1:0]           wr_ptr_i,
   input  logic [DATA_W-1:0]          wr_data_i,
   input  logic [PTR_W-1:0]           rd_ptr_i,
   output logic [DATA_W-1:0]          rd_data_o,
   output logic [NUM_REGS*DATA_W-1:0] regs_o
);
   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      logic [DATA_W-1:0] val_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            val_q <= DATA_W'(RST_VAL);
         else if (wr_en_i && (wr_ptr_i == PTR_W'(i)))
            val_q <= wr_data_i;
      end
      assign regs_o[i*DATA_W +: DATA_W] = val_q;
   end

   assign rd_data_o = regs_o[rd_ptr_i*DATA_W +: DATA_W];

endmodule

// File: rtl/twi_cfg_slave.sv
module twi_cfg_slave
   import twi_cfg_pkg::*;
#(
   parameter logic [6:0] ADDR_BASE   = 7'h28,
   parameter int         NUM_REGS    = 16,
   parameter int         SYS_CLK_PS  = 10000,
   parameter int         REJECT_PS   = 50000,
   parameter int         SYNC_STAGES = 2,
   parameter logic [7:0] REG_RST     = 8'h00,
   localparam int        PTR_W       = $clog2(NUM_REGS),
   localparam int        FILT_CYCLES = persist_cycles(SYS_CLK_PS, REJECT_PS)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       scl_i,
   input  logic                       sda_i,
   input  logic                       strap_i,
   output logic                       sda_oe_o,
   output logic [NUM_REGS*BYTE_W-1:0] cfg_regs_o
);
   if (NUM_REGS < 2 || NUM_REGS > 256 || (NUM_REGS & (NUM_REGS - 1)) != 0) begin : g_bad_regs
      $error("twi_cfg_slave: NUM_REGS must be a power of two from 2 to 256");
   end
   if (SYS_CLK_PS <= 0 || REJECT_PS <= 0) begin : g_bad_time
      $error("twi_cfg_slave: clock period and reject width must be positive");
   end

   // ---------------- line conditioning ----------------
   logic [1:0] raw_lines;
   logic [1:0] clean_lines;
   assign raw_lines = {sda_i, scl_i};

   for (genvar g = 0; g < 2; g++) begin : g_line
      twi_line_filter #(
         .SYNC_STAGES (SYNC_STAGES),
         .FILT_CYCLES (FILT_CYCLES)
      ) u_filt (
         .clk       (clk),
         .rst_n     (rst_n),
         .line_i    (raw_lines[g]),
         .filt_en_i (strap_i),
         .line_o    (clean_lines[g])
      );
   end

   logic sda_f;
   logic scl_rise, scl_fall, start_det, stop_det;
   assign sda_f = clean_lines[1];

   twi_bus_cond u_cond (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (clean_lines[0]),
      .sda_i      (sda_f),
      .scl_rise_o (scl_rise),
      .scl_fall_o (scl_fall),
      .start_o    (start_det),
      .stop_o     (stop_det)
   );

   // ---------------- protocol state ----------------
   twi_state_e         state_q;
   logic [3:0]         bit_cnt_q;
   logic [BYTE_W-1:0]  shreg_q;
   logic               ack_ph_q;
   logic               rw_q;
   logic               mack_q;
   logic               oe_q;
   logic [PTR_W-1:0]   ptr_q;
   logic [BYTE_W-1:0]  rd_data;
   logic [DEV_ADDR_W-1:0] own_addr;
   logic               byte_done;
   logic               wr_en;

   assign own_addr  = {ADDR_BASE[6:2], strap_i, ADDR_BASE[0]};
   assign byte_done = scl_fall && !ack_ph_q && (bit_cnt_q == 4'd8);
   assign wr_en     = (state_q == ST_WDATA) && byte_done && !start_det && !stop_det;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         bit_cnt_q <= '0;
         shreg_q   <= '0;
         ack_ph_q  <= 1'b0;
         rw_q      <= 1'b0;
         mack_q    <= 1'b0;
         oe_q      <= 1'b0;
         ptr_q     <= '0;
      end else if (start_det) begin
         state_q   <= ST_ADDR;
         bit_cnt_q <= '0;
         ack_ph_q  <= 1'b0;
         oe_q      <= 1'b0;
      end else if (stop_det) begin
         state_q   <= ST_IDLE;
         bit_cnt_q <= '0;
         ack_ph_q  <= 1'b0;
         oe_q      <= 1'b0;
      end else begin
         case (state_q)
            ST_ADDR, ST_SUBA, ST_WDATA: begin
               if (scl_rise && !ack_ph_q) begin
                  shreg_q   <= {shreg_q[BYTE_W-2:0], sda_f};
                  bit_cnt_q <= bit_cnt_q + 4'd1;
               end
               if (scl_fall && ack_ph_q) begin
                  ack_ph_q  <= 1'b0;
                  bit_cnt_q <= '0;
                  oe_q      <= 1'b0;
                  if (state_q == ST_ADDR) begin
                     if (rw_q) begin
                        state_q <= ST_RDATA;
                        shreg_q <= rd_data;
                        oe_q    <= ~rd_data[BYTE_W-1];
                     end else begin
                        state_q <= ST_SUBA;
                     end
                  end else if (state_q == ST_SUBA) begin
                     state_q <= ST_WDATA;
                  end
               end else if (byte_done) begin
                  case (state_q)
                     ST_ADDR: begin
                        if (shreg_q[BYTE_W-1:1] == own_addr) begin
                           rw_q     <= shreg_q[0];
                           oe_q     <= 1'b1;
                           ack_ph_q <= 1'b1;
                        end else begin
                           state_q   <= ST_IDLE;
                           bit_cnt_q <= '0;
                        end
                     end
                     ST_SUBA: begin
                        ptr_q    <= shreg_q[PTR_W-1:0];
                        oe_q     <= 1'b1;
                        ack_ph_q <= 1'b1;
                     end
                     default: begin
                        ptr_q    <= ptr_q + PTR_W'(1);
                        oe_q     <= 1'b1;
                        ack_ph_q <= 1'b1;
                     end
                  endcase
               end
            end
            ST_RDATA: begin
               if (scl_rise) begin
                  if (ack_ph_q) mack_q    <= ~sda_f;
                  else          bit_cnt_q <= bit_cnt_q + 4'd1;
               end
               if (scl_fall) begin
                  if (ack_ph_q) begin
                     ack_ph_q  <= 1'b0;
                     bit_cnt_q <= '0;
                     if (mack_q) begin
                        shreg_q <= rd_data;
                        oe_q    <= ~rd_data[BYTE_W-1];
                     end else begin
                        state_q <= ST_IDLE;
                     end
                  end else if (bit_cnt_q == 4'd8) begin
                     oe_q     <= 1'b0;
                     ack_ph_q <= 1'b1;
                     ptr_q    <= ptr_q + PTR_W'(1);
                  end else begin
                     shreg_q <= {shreg_q[BYTE_W-2:0], 1'b0};
                     oe_q    <= ~shreg_q[BYTE_W-2];
                  end
               end
            end
            default: ;
         endcase
      end
   end

   assign sda_oe_o = oe_q;

   // ---------------- register storage ----------------
   twi_reg_bank #(
      .NUM_REGS (NUM_REGS),
      .DATA_W   (BYTE_W),
      .RST_VAL  (REG_RST)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (wr_en),
      .wr_ptr_i  (ptr_q),
      .wr_data_i (shreg_q),
      .rd_ptr_i  (ptr_q),
      .rd_data_o (rd_data),
      .regs_o    (cfg_regs_o)
   );

endmodule

// File: rtl/twi_cfg_slave_chk.sv
module twi_cfg_slave_chk #(
   parameter int PTR_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sda_oe_o,
   input logic             scl_fall,
   input logic             start_det,
   input logic             stop_det,
   input logic [3:0]       bit_cnt,
   input logic             wr_en,
   input logic [PTR_W-1:0] ptr
);
   // R12
   oe_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe_o) |-> $past(scl_fall || start_det || stop_det));

   // R9
   stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (!sda_oe_o && bit_cnt == 4'd0));

   // R2
   start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> (!sda_oe_o && bit_cnt == 4'd0));

   // R5
   ptr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (ptr == $past(ptr) + PTR_W'(1)));

   // R5
   wr_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (scl_fall && !start_det && !stop_det));

endmodule

bind twi_cfg_slave twi_cfg_slave_chk #(.PTR_W(PTR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sda_oe_o  (sda_oe_o),
   .scl_fall  (scl_fall),
   .start_det (start_det),
   .stop_det  (stop_det),
   .bit_cnt   (bit_cnt_q),
   .wr_en     (wr_en),
   .ptr       (ptr_q)
);

// File: tb/twi_cfg_slave_bench.sv
`timescale 1ns/1ps
module twi_cfg_slave_bench;
   localparam int NREG = 16;
   localparam int QP   = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic strap = 1'b0;
   logic sda_oe;
   logic sda_line;
   logic [NREG*8-1:0] regs;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   assign sda_line = sda_m & ~sda_oe;

   twi_cfg_slave u_twi_cfg_slave (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl_m),
      .sda_i      (sda_line),
      .strap_i    (strap),
      .sda_oe_o   (sda_oe),
      .cfg_regs_o (regs)
   );

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] reg_at(input int k);
      return regs[k*8 +: 8];
   endfunction

   task automatic hold(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start;
      sda_m = 1'b1; hold(QP);
      scl_m = 1'b1; hold(QP);
      sda_m = 1'b0; hold(QP);
      scl_m = 1'b0; hold(QP);
   endtask

   task automatic bus_stop;
      sda_m = 1'b0; hold(QP);
      scl_m = 1'b1; hold(QP);
      sda_m = 1'b1; hold(QP);
   endtask

   task automatic put_bit(input logic b);
      sda_m = b;    hold(QP);
      scl_m = 1'b1; hold(2*QP);
      scl_m = 1'b0; hold(QP);
   endtask

   task automatic get_bit(output logic b);
      sda_m = 1'b1; hold(QP);
      scl_m = 1'b1; hold(QP);
      b = sda_line; hold(QP);
      scl_m = 1'b0; hold(QP);
   endtask

   // mode 0: data spike during clock high; mode 1: clock spike during clock low
   task automatic spiky_bit(input logic b, input int mode);
      sda_m = b;
      if (mode == 0) begin
         hold(QP);
         scl_m = 1'b1; hold(QP/2);
         sda_m = 1'b0; hold(3);
         sda_m = b;    hold(QP + QP/2 - 3);
         scl_m = 1'b0; hold(QP);
      end else begin
         hold(QP/2);
         scl_m = 1'b1; hold(3);
         scl_m = 1'b0; hold(QP/2 - 3);
         scl_m = 1'b1; hold(2*QP);
         scl_m = 1'b0; hold(QP);
      end
   endtask

   task automatic tx_byte(input logic [7:0] d, output bit acked);
      logic b;
      for (int i = 7; i >= 0; i--) put_bit(d[i]);
      get_bit(b);
      acked = !b;
   endtask

   task automatic tx_spiky(input logic [7:0] d, output bit acked);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         if (i == 7)      spiky_bit(d[i], 0);
         else if (i == 4) spiky_bit(d[i], 1);
         else             put_bit(d[i]);
      end
      get_bit(b);
      acked = !b;
   endtask

   task automatic rx_byte(output logic [7:0] d, input bit give_ack);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         get_bit(b);
         d[i] = b;
      end
      put_bit(!give_ack);
   endtask

   task automatic t_reset;
      bit all_zero = 1'b1;
      chk(sda_oe == 1'b0, "R1", "oe after reset", int'(sda_oe), 0);
      for (int k = 0; k < NREG; k++) if (reg_at(k) != 8'h00) all_zero = 1'b0;
      chk(all_zero, "R1", "registers after reset", int'(all_zero), 1);
   endtask

   task automatic t_write_basic;
      bit a;
      strap = 1'b0; hold(4);
      bus_start;
      tx_byte(8'h50, a); chk(a, "R4", "address ack 0x28 write", int'(a), 1);
      tx_byte(8'h03, a); chk(a, "R5", "pointer byte ack", int'(a), 1);
      tx_byte(8'hA5, a); chk(a, "R5", "data byte ack", int'(a), 1);
      tx_byte(8'h5C, a); chk(a, "R5", "second data ack", int'(a), 1);
      bus_stop;
      chk(reg_at(3) == 8'hA5, "R5", "reg3", int'(reg_at(3)), 'hA5);
      chk(reg_at(4) == 8'h5C, "R5", "reg4 auto-increment", int'(reg_at(4)), 'h5C);
   endtask

   task automatic t_read_back;
      bit a;
      logic [7:0] d;
      logic b;
      bus_start;
      tx_byte(8'h50, a);
      tx_byte(8'h03, a);
      bus_start;
      tx_byte(8'h51, a); chk(a, "R3", "read address ack", int'(a), 1);
      rx_byte(d, 1'b1);  chk(d == 8'hA5, "R7", "first read byte", int'(d), 'hA5);
      rx_byte(d, 1'b0);  chk(d == 8'h5C, "R7", "second read byte", int'(d), 'h5C);
      hold(2);
      chk(sda_oe == 1'b0, "R8", "released after nack", int'(sda_oe), 0);
      get_bit(b);
      chk(b == 1'b1, "R8", "silent after nack", int'(b), 1);
      bus_stop;
   endtask

   task automatic t_wrong_addr;
      bit a;
      bus_start;
      tx_byte(8'h54, a); chk(!a, "R4", "no ack for 0x2A with strap low", int'(a), 0);
      tx_byte(8'h07, a);
      tx_byte(8'hEE, a); chk(!a, "R4", "no ack after mismatch", int'(a), 0);
      bus_stop;
      chk(reg_at(7) == 8'h00, "R4", "reg7 untouched", int'(reg_at(7)), 0);
   endtask

   task automatic t_strap_addr;
      bit a;
      strap = 1'b1; hold(20);
      bus_start;
      tx_byte(8'h54, a); chk(a, "R3", "ack 0x2A with strap high", int'(a), 1);
      tx_byte(8'h07, a);
      tx_byte(8'h3C, a);
      bus_stop;
      chk(reg_at(7) == 8'h3C, "R3", "reg7 via strapped address", int'(reg_at(7)), 'h3C);
      bus_start;
      tx_byte(8'h50, a); chk(!a, "R3", "no ack 0x28 with strap high", int'(a), 0);
      bus_stop;
      strap = 1'b0; hold(20);
   endtask

   task automatic t_wrap;
      bit a;
      bus_start;
      tx_byte(8'h50, a);
      tx_byte(8'h0F, a);
      tx_byte(8'h11, a);
      tx_byte(8'h22, a);
      bus_stop;
      chk(reg_at(15) == 8'h11, "R6", "reg15", int'(reg_at(15)), 'h11);
      chk(reg_at(0) == 8'h22, "R6", "wrap to reg0", int'(reg_at(0)), 'h22);
   endtask

   task automatic t_abort;
      bit a;
      bus_start;
      tx_byte(8'h50, a);
      tx_byte(8'h09, a);
      tx_byte(8'h77, a);
      for (int i = 0; i < 4; i++) put_bit(1'b1);
      bus_stop;
      chk(reg_at(9) == 8'h77, "R9", "reg9 complete byte", int'(reg_at(9)), 'h77);
      chk(reg_at(10) == 8'h00, "R9", "reg10 partial byte dropped", int'(reg_at(10)), 0);
      chk(sda_oe == 1'b0, "R9", "released after stop", int'(sda_oe), 0);
      bus_start;
      tx_byte(8'h50, a);
      tx_byte(8'h0C, a);
      for (int i = 0; i < 3; i++) put_bit(1'b1);
      bus_start;
      tx_byte(8'h50, a); chk(a, "R2", "ack after mid-byte restart", int'(a), 1);
      tx_byte(8'h0C, a);
      tx_byte(8'h99, a);
      bus_stop;
      chk(reg_at(12) == 8'h99, "R2", "reg12 after restart", int'(reg_at(12)), 'h99);
      chk(reg_at(13) == 8'h00, "R2", "reg13 untouched", int'(reg_at(13)), 0);
   endtask

   task automatic t_filter_on;
      bit a;
      strap = 1'b1; hold(20);
      bus_start;
      tx_byte(8'h54, a);
      tx_byte(8'h05, a);
      tx_spiky(8'hF0, a); chk(a, "R10", "ack despite spikes", int'(a), 1);
      bus_stop;
      chk(reg_at(5) == 8'hF0, "R10", "reg5 despite spikes", int'(reg_at(5)), 'hF0);
      strap = 1'b0; hold(20);
   endtask

   task automatic t_filter_off;
      bit a;
      bus_start;
      tx_byte(8'h50, a);
      tx_byte(8'h06, a);
      tx_spiky(8'hF0, a); chk(!a, "R11", "spike aborts transfer", int'(a), 0);
      bus_stop;
      chk(reg_at(6) == 8'h00, "R11", "reg6 not written", int'(reg_at(6)), 0);
   endtask

   task automatic report;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      hold(5);
      rst_n = 1'b1;
      hold(5);
      t_reset;
      t_write_basic;
      t_read_back;
      t_wrong_addr;
      t_strap_addr;
      t_wrap;
      t_abort;
      t_filter_on;
      t_filter_off;
      hold(10);
      report;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      report;
   end

endmodule